// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a queue of up to 32 transfer entries with no processor involvement between transfers. Each queue slot holds a transmit word and a command word. The command word sets the transfer length, from 8 to 16 bits, and a 4-bit peripheral-select code. An external decoder can turn that code into one of 16 device selects. The received word of every transfer is written back to a receive RAM, in the slot of the command that produced it.

Software fills the transmit and command RAMs and sets the SCK divider. It then writes the control word, which holds a start pointer, an end pointer, a wrap flag and an enable bit. In single-pass mode the controller runs from the start slot to the end slot and raises `irq_o`. In wrap mode it returns to the start slot after the end slot. It keeps cycling, which suits continuous sampling of a serial converter, until software clears the enable bit.

Top module: `qspi_master`

## Requirements
- R1: After reset `sck_o` and `mosi_o` are low, `pcs_o` is 4'b1111 and `irq_o` is low.
- R2: Command word bits [3:0] give the transfer length: code 0 means 16 bits, codes 1 to 7 mean 8 bits, and codes 8 to 15 mean that many bits. The low bits of the transmit word are sent, most significant first.
- R3: Each transfer is full duplex: one MISO bit is captured per SCK period. The received bits are right-justified with zero fill and stored in the receive RAM at the same slot as the command.
- R4: SCK idles low. MOSI changes on falling edges and MISO is sampled on rising edges. Each SCK half period lasts max(N,2) clock cycles, where N is the divider register value, so the fastest SCK is the clock divided by 4.
- R5: `pcs_o` carries command bits [7:4] from at least one half period before the first rising SCK edge of a transfer until that transfer ends. It reads 4'b1111 whenever the queue is not running.
- R6: With wrap off, the pointer steps from the start slot to the end slot, modulo 32. After the end slot's transfer the queue halts, the enable bit clears and `irq_o` sets.
- R7: With wrap on, the slot after the end slot is the start slot again, and `irq_o` never sets. Clearing the enable bit stops the queue at the next transfer boundary, so no transfer is cut short.
- R8: Write targets are selected by `wr_sel_i`: 0 for transmit RAM, 1 for command RAM, 2 for control, 3 for divider (bits [7:0]). Control bits are: [4:0] start, [9:5] end, [10] wrap, [11] enable. Any control write clears `irq_o`. A control write with enable set starts the queue if it is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_addr_i | input | 5 | Queue slot for RAM writes |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 5 | Receive RAM read slot |
| rd_data_o | output | 16 | Receive RAM read data |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| pcs_o | output | 4 | Peripheral-select code |
| irq_o | output | 1 | Queue-done flag |

## Verification
The hardest case to reach is the wrap-around loop being stopped mid-run. It needs a queue that crosses slot 31 back to slot 0 and has looped several times. The enable bit must then drop while a transfer is in flight. The bench ties MISO to the inverse of MOSI and logs every rising SCK edge with its select code and data bit. It clears enable only after more than two full loops. It then checks three things: the logged stream is a whole number of frames in the expected slot order, no further edges appear, and the done flag never rose.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_LOAD, SEQ_XFER} seq_state_e;

  localparam int DATA_W = 16;
  localparam int PCS_W  = 4;
  localparam int LEN_W  = 5;

  function automatic logic [LEN_W-1:0] len_decode(input logic [3:0] code);
    if (code == 4'd0)      return LEN_W'(16);
    else if (code < 4'd8)  return LEN_W'(8);
    else                   return {1'b0, code};
  endfunction
endpackage

// File: rtl/qspi_ram.sv
module qspi_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
  parameter int DW    = 16,
  parameter int DIV_W = 8,
  localparam int CW   = $clog2(DW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DW-1:0]    data_i,
  input  logic [CW-1:0]    nbits_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    rx_o
);
  logic [DIV_W-1:0] tmr_q;
  logic [CW-1:0]    left_q;
  logic [DW-1:0]    tx_q, rx_q;
  logic             sck_q, busy_q, done_q;
  logic             tick;

  assign tick = (tmr_q == half_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      left_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        tmr_q  <= '0;
        left_q <= nbits_i;
        tx_q   <= data_i << (CW'(DW) - nbits_i);  // MSB-align
        rx_q   <= '0;
      end else if (busy_q) begin
        if (tick) begin
          tmr_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[DW-2:0], miso_i};
          end else begin
            sck_q  <= 1'b0;
            tx_q   <= {tx_q[DW-2:0], 1'b0};
            left_q <= left_q - CW'(1);
            if (left_q == CW'(1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          tmr_q <= tmr_q + DIV_W'(1);
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = busy_q & tx_q[DW-1];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R4
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);

  // R2
  bit_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (left_q != '0) && (left_q <= CW'(DW)));
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic [DATA_W-1:0] ctrl_data_i,
  input  logic [PCS_W-1:0] pcs_code_i,
  input  logic             sh_done_i,
  input  logic             sh_busy_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             load_o,
  output logic             rx_we_o,
  output logic [PCS_W-1:0] pcs_o,
  output logic             done_o
);
  localparam int WRAP_B = 2 * IDX_W;
  localparam int EN_B   = 2 * IDX_W + 1;
  localparam logic [PCS_W-1:0] PCS_IDLE = '1;

  seq_state_e       state_q;
  logic [IDX_W-1:0] ptr_q, start_q, end_q;
  logic             wrap_q, en_q, done_q;
  logic [PCS_W-1:0] pcs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ptr_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
      wrap_q  <= 1'b0;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      pcs_q   <= PCS_IDLE;
    end else begin
      if (ctrl_wr_i) begin
        start_q <= ctrl_data_i[IDX_W-1:0];
        end_q   <= ctrl_data_i[2*IDX_W-1:IDX_W];
        wrap_q  <= ctrl_data_i[WRAP_B];
        en_q    <= ctrl_data_i[EN_B];
        done_q  <= 1'b0;
      end
      unique case (state_q)
        SEQ_IDLE: begin
          pcs_q <= PCS_IDLE;
          if (ctrl_wr_i && ctrl_data_i[EN_B]) begin
            ptr_q   <= ctrl_data_i[IDX_W-1:0];
            state_q <= SEQ_LOAD;
          end
        end
        SEQ_LOAD: begin
          pcs_q   <= pcs_code_i;
          state_q <= SEQ_XFER;
        end
        SEQ_XFER: begin
          if (sh_done_i) begin
            if (ptr_q == end_q) begin
              if (wrap_q && en_q) begin
                ptr_q   <= start_q;
                state_q <= SEQ_LOAD;
              end else begin
                state_q <= SEQ_IDLE;
                en_q    <= 1'b0;
                if (!wrap_q) done_q <= 1'b1;
              end
            end else if (en_q) begin
              ptr_q   <= ptr_q + IDX_W'(1);
              state_q <= SEQ_LOAD;
            end else begin
              state_q <= SEQ_IDLE;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign ptr_o   = ptr_q;
  assign load_o  = (state_q == SEQ_LOAD);
  assign rx_we_o = (state_q == SEQ_XFER) && sh_done_i;
  assign pcs_o   = pcs_q;
  assign done_o  = done_q;

  // R5
  pcs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_busy_i && $past(sh_busy_i) |-> $stable(pcs_o));

  // R6
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (ptr_q == end_q) && (state_q == SEQ_IDLE));
endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DIV_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [PCS_W-1:0]  pcs_o,
  output logic              irq_o
);
  logic [IDX_W-1:0]  ptr;
  logic [DATA_W-1:0] tx_word, cmd_word, rx_word;
  logic              load, rx_we, sh_done, sh_busy;
  logic [DIV_W-1:0]  div_q, half_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          div_q <= '0;
    else if (wr_en_i && wr_sel_i == 2'd3) div_q <= wr_data_i[DIV_W-1:0];
  end

  assign half_eff = (div_q < DIV_W'(2)) ? DIV_W'(2) : div_q;

  qspi_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_ram (
    .clk_i, .we_i(wr_en_i && wr_sel_i == 2'd0), .waddr_i(wr_addr_i),
    .wdata_i(wr_data_i), .raddr_i(ptr), .rdata_o(tx_word));

  qspi_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_cmd_ram (
    .clk_i, .we_i(wr_en_i && wr_sel_i == 2'd1), .waddr_i(wr_addr_i),
    .wdata_i(wr_data_i), .raddr_i(ptr), .rdata_o(cmd_word));

  qspi_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_ram (
    .clk_i, .we_i(rx_we), .waddr_i(ptr),
    .wdata_i(rx_word), .raddr_i(rd_addr_i), .rdata_o(rd_data_o));

  qspi_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni,
    .ctrl_wr_i(wr_en_i && wr_sel_i == 2'd2), .ctrl_data_i(wr_data_i),
    .pcs_code_i(cmd_word[7:4]), .sh_done_i(sh_done), .sh_busy_i(sh_busy),
    .ptr_o(ptr), .load_o(load), .rx_we_o(rx_we), .pcs_o(pcs_o), .done_o(irq_o));

  qspi_shift #(.DW(DATA_W), .DIV_W(DIV_W)) u_shift (
    .clk_i, .rst_ni, .start_i(load), .data_i(tx_word),
    .nbits_i(len_decode(cmd_word[3:0])), .half_i(half_eff), .miso_i,
    .sck_o, .mosi_o, .busy_o(sh_busy), .done_o(sh_done), .rx_o(rx_word));
endmodule

// File: tb/qspi_master_test.sv
module qspi_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic sck, mosi, miso;
  logic [3:0] pcs;
  logic irq;

  int n_chk = 0, n_fail = 0, cyc = 0, n_edges = 0;
  logic [3:0] e_pcs [0:4095];
  logic       e_bit [0:4095];
  int         e_t   [0:4095];
  logic       sck_prev = 1'b0;
  logic [15:0] txv [0:31];

  always #4 clk = ~clk;
  assign miso = ~mosi;

  qspi_master uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .sck_o(sck), .mosi_o(mosi), .miso_i(miso),
    .pcs_o(pcs), .irq_o(irq));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sck && !sck_prev && n_edges < 4096) begin
      e_pcs[n_edges] = pcs;
      e_bit[n_edges] = mosi;
      e_t[n_edges]   = cyc;
      n_edges = n_edges + 1;
    end
    sck_prev = sck;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic int nb(input int code);
    if (code == 0) return 16;
    if (code < 8) return 8;
    return code;
  endfunction

  function automatic logic [15:0] ctrl(input int s, input int e, input bit w, input bit en);
    return 16'(s) | (16'(e) << 5) | (16'(w) << 10) | (16'(en) << 11);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int base, bad, nbits, cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sck == 1'b0, "R1 sck", sck, 0);
    chk(mosi == 1'b0, "R1 mosi", mosi, 0);
    chk(pcs == 4'hF, "R1 pcs", pcs, 4'hF);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rst_n = 1'b1;

    // Sweep every length code; slot i uses length code i and select i
    for (int i = 0; i < 16; i++) begin
      txv[i] = 16'hA5C3 ^ (16'(i) * 16'h1357);
      wr(2'd0, 5'(i), txv[i]);
      wr(2'd1, 5'(i), 16'((i << 4) | i));
    end
    wr(2'd3, 5'd0, 16'd0);
    n_edges = 0;
    wr(2'd2, 5'd0, ctrl(0, 15, 1'b0, 1'b1));
    while (!irq) @(negedge clk);
    chk(irq == 1'b1, "R6 irq set", irq, 1);
    repeat (20) @(negedge clk);
    chk(sck == 1'b0, "R6 halted sck", sck, 0);
    chk(pcs == 4'hF, "R5 idle pcs", pcs, 4'hF);
    base = 0;
    for (int i = 0; i < 16; i++) begin
      nbits = nb(i);
      bad = 0;
      for (int k = 0; k < nbits; k++) begin
        if (e_bit[base + k] !== txv[i][nbits - 1 - k]) bad++;
        if (e_pcs[base + k] !== 4'(i)) bad++;
      end
      chk(bad == 0, "R2 R5 stream per slot", bad, 0);
      base += nbits;
      rd(5'(i), d);
      chk(d == ((~txv[i]) & 16'((32'h1 << nbits) - 1)), "R3 rx word", d,
          (~txv[i]) & 16'((32'h1 << nbits) - 1));
    end
    chk(n_edges == base, "R2 total sck edges", n_edges, base);
    chk(e_t[1] - e_t[0] == 4, "R4 fastest period", e_t[1] - e_t[0], 4);

    // R8 control write clears irq
    wr(2'd2, 5'd0, ctrl(0, 0, 1'b0, 1'b0));
    chk(irq == 1'b0, "R8 irq cleared", irq, 0);

    // R4 divider sweep on one slot with start == end
    wr(2'd0, 5'd20, 16'h00B6);
    wr(2'd1, 5'd20, 16'h0098);
    for (int j = 0; j < 5; j++) begin
      int nv, eff;
      nv = (j == 0) ? 1 : (j == 1) ? 2 : (j == 2) ? 3 : (j == 3) ? 5 : 7;
      eff = (nv < 2) ? 2 : nv;
      wr(2'd3, 5'd0, 16'(nv));
      n_edges = 0;
      wr(2'd2, 5'd0, ctrl(20, 20, 1'b0, 1'b1));
      while (!irq) @(negedge clk);
      chk(e_t[1] - e_t[0] == 2 * eff, "R4 half period", e_t[1] - e_t[0], 2 * eff);
      chk(n_edges == 8, "R6 single slot", n_edges, 8);
      chk(e_pcs[0] == 4'h9, "R5 select code", e_pcs[0], 9);
      rd(5'd20, d);
      chk(d == 16'h0049, "R3 rx slot 20", d, 16'h0049);
    end

    // R7 wrap across slot 31 -> 0
    begin
      int ord [4];
      logic [3:0] cs [4];
      ord = '{30, 31, 0, 1};
      cs  = '{4'h3, 4'h7, 4'hB, 4'hD};
      for (int i = 0; i < 4; i++) begin
        txv[ord[i]] = 16'h3C00 | 16'(8'h1D * (i + 1));
        wr(2'd0, 5'(ord[i]), txv[ord[i]]);
        wr(2'd1, 5'(ord[i]), 16'({cs[i], 4'h8}));
      end
      wr(2'd3, 5'd0, 16'd0);
      n_edges = 0;
      wr(2'd2, 5'd0, ctrl(30, 1, 1'b1, 1'b1));
      chk(irq == 1'b0, "R8 irq cleared on start", irq, 0);
      while (n_edges < 8 * 9 + 3) @(negedge clk);
      wr(2'd2, 5'd0, ctrl(30, 1, 1'b1, 1'b0));
      repeat (200) @(negedge clk);
      cnt = n_edges;
      repeat (100) @(negedge clk);
      chk(n_edges == cnt, "R7 stopped", n_edges, cnt);
      chk(cnt % 8 == 0, "R7 whole frames", cnt % 8, 0);
      chk(irq == 1'b0, "R7 no irq", irq, 0);
      chk(pcs == 4'hF, "R5 idle after stop", pcs, 4'hF);
      bad = 0;
      for (int e = 0; e < cnt; e++) begin
        int f;
        f = (e / 8) % 4;
        if (e_pcs[e] !== cs[f]) bad++;
        if (e_bit[e] !== txv[ord[f]][7 - (e % 8)]) bad++;
      end
      chk(bad == 0, "R7 wrap order", bad, 0);
      for (int i = 0; i < 4; i++) begin
        rd(5'(ord[i]), d);
        chk(d == ((~txv[ord[i]]) & 16'h00FF), "R3 wrap rx", d, (~txv[ord[i]]) & 16'h00FF);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule